// File: doc/BRIEF.md
# Tag-Addressed Reorder Buffer

This block keeps program order for a small out-of-order core. Each dispatched instruction claims the next free slot of a circular buffer and gets that slot's index back as its tag. The slot records the destination architectural register and the instruction address at dispatch. Execution units may then finish in any order. Each one writes its result and two status flags straight into the slot its tag names: an exception event, and a branch whose computed target differs from the predicted one.

The oldest slot is presented for retirement as soon as its result is in. A clean slot drives a register-file update. A slot carrying either flag does not write a register. It raises a flush request with the instruction's address instead, and on the next cycle every younger slot is discarded. Up to two completions can be written in one cycle. At most one slot is allocated and one is retired per cycle. All outputs depend only on registered state.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: disp_ready is 1, disp_tag is 0, and ret_valid and flush_req are 0.
- R2: A slot is allocated on a clock edge where disp_valid and disp_ready are both 1. disp_tag shows the index of the slot the next allocation takes. Successive allocations take consecutive indices, starting from 0 after reset.
- R3: Each of the two completion ports, when its cmp_valid bit is 1, writes its value, exception bit and mismatch bit into the slot named by its tag. Both ports can write in the same cycle.
- R4: Only the oldest slot retires, and only once its result has been written. A younger finished slot waits. ret_valid or flush_req appears in the cycle after the edge that completes the oldest slot, and at most one slot retires per cycle.
- R5: A clean retirement shows ret_valid=1 with ret_dest equal to the register given at dispatch and ret_value equal to the completed value.
- R6: With 16 slots outstanding, disp_ready is 0 and dispatch attempts are ignored. disp_ready returns in the cycle after a retirement.
- R7: Retiring a slot whose exception bit is 1 drives flush_req=1 with flush_pc equal to that slot's dispatch address, and ret_valid=0.
- R8: Retiring a slot whose mismatch bit is 1 behaves as R7.
- R9: In the cycle after a flush the buffer is empty. Younger slots are discarded even if finished, and the next tag is the flagged slot's index plus one, modulo 16.
- R10: A completion addressed to an unallocated slot has no effect. No dispatch is accepted in a flush cycle (disp_ready=0).
- R11: Tags wrap from 15 to 0 and the buffer keeps working across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_dest | input | 5 | Destination architectural register |
| disp_pc | input | 32 | Instruction address |
| disp_ready | output | 1 | A slot can be allocated this cycle |
| disp_tag | output | 4 | Index of the slot the next allocation takes |
| cmp_valid | input | 2 | Completion strobe per port |
| cmp_tag | input | 2x4 | Completion tag per port |
| cmp_value | input | 2x32 | Result value per port |
| cmp_exc | input | 2 | Exception event per port |
| cmp_mis | input | 2 | Branch target mismatch per port |
| ret_valid | output | 1 | Register update from the oldest slot |
| ret_dest | output | 5 | Register number of the update |
| ret_value | output | 32 | Value of the update |
| flush_req | output | 1 | Oldest slot is flagged; flush the pipeline |
| flush_pc | output | 32 | Address of the flagged instruction |

## Verification
The assertions assume that completions only name tags that are outstanding. They also assume each outstanding tag completes once, and that the two ports never carry the same tag in one cycle. The stimulus keeps to this: every completion targets a slot the bench has allocated and not yet seen retire. The one exception is a single deliberate write to a free slot, which tests that such writes are dropped. The bench raises disp_valid against a full buffer only in a cycle it has checked as full, so dispatch never depends on a retirement in the same edge.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef struct packed {
    logic exc;
    logic mis;
  } rob_status_t;

  function automatic logic needs_flush(rob_status_t s);
    return s.exc | s.mis;
  endfunction

  // Number of occupied slots from wrap-bit pointers of width pw.
  function automatic int unsigned occupancy(int unsigned head, int unsigned tail, int unsigned pw);
    int unsigned m;
    m = (32'd1 << pw) - 32'd1;
    return (tail - head) & m;
  endfunction

endpackage

// File: rtl/rob_slot.sv
module rob_slot #(
  parameter int IDX    = 0,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int PC_W   = 32,
  parameter int NCMP   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear_all,
  input  logic                        release_i,
  input  logic                        alloc_i,
  input  logic [AREG_W-1:0]           alloc_dest,
  input  logic [PC_W-1:0]             alloc_pc,
  input  logic [NCMP-1:0]             cmp_valid,
  input  logic [NCMP-1:0][TAG_W-1:0]  cmp_tag,
  input  logic [NCMP-1:0][DATA_W-1:0] cmp_value,
  input  logic [NCMP-1:0]             cmp_exc,
  input  logic [NCMP-1:0]             cmp_mis,
  output logic                        valid_o,
  output logic                        done_o,
  output rob_pkg::rob_status_t        status_o,
  output logic [AREG_W-1:0]           dest_o,
  output logic [PC_W-1:0]             pc_o,
  output logic [DATA_W-1:0]           value_o
);
  localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(IDX);

  logic                 valid_q, done_q;
  rob_pkg::rob_status_t st_q;
  logic [AREG_W-1:0]    dest_q;
  logic [PC_W-1:0]      pc_q;
  logic [DATA_W-1:0]    value_q;
  logic [NCMP-1:0]      hit;

  always_comb begin
    for (int k = 0; k < NCMP; k++) hit[k] = cmp_valid[k] && (cmp_tag[k] == MY_TAG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      st_q    <= '0;
      dest_q  <= '0;
      pc_q    <= '0;
      value_q <= '0;
    end else if (clear_all) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (release_i) begin
        valid_q <= 1'b0;
        done_q  <= 1'b0;
      end
      if (alloc_i) begin
        valid_q <= 1'b1;
        done_q  <= 1'b0;
        st_q    <= '0;
        dest_q  <= alloc_dest;
        pc_q    <= alloc_pc;
      end
      for (int k = 0; k < NCMP; k++) begin
        if (hit[k] && valid_q) begin
          done_q     <= 1'b1;
          value_q    <= cmp_value[k];
          st_q.exc   <= cmp_exc[k];
          st_q.mis   <= cmp_mis[k];
        end
      end
    end
  end

  assign valid_o  = valid_q;
  assign done_o   = done_q;
  assign status_o = st_q;
  assign dest_o   = dest_q;
  assign pc_o     = pc_q;
  assign value_o  = value_q;

  AST_FREE_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit && !valid_q && !alloc_i) |=> !done_q);  // R10
  AST_ALLOC_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_i && !clear_all) |=> (valid_q && !done_q));  // R2

endmodule

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc,
  input  logic             retire,
  input  logic             flush,
  output logic [PTR_W-1:0] head_ptr,
  output logic [PTR_W-1:0] tail_ptr,
  output logic             full,
  output logic             empty
);
  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  logic [PTR_W-1:0] head_q, tail_q;
  int unsigned      occ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      head_q <= head_q + ONE;
      tail_q <= head_q + ONE;
    end else begin
      if (alloc)  tail_q <= tail_q + ONE;
      if (retire) head_q <= head_q + ONE;
    end
  end

  always_comb begin
    occ   = rob_pkg::occupancy(32'(head_q), 32'(tail_q), PTR_W);
    full  = (occ == DEPTH);
    empty = (occ == 0);
  end

  assign head_ptr = head_q;
  assign tail_ptr = tail_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH);  // R6
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc);  // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);  // R9
  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (head_q == $past(head_q) + ONE));  // R4

endmodule

// File: rtl/rob_retire.sv
module rob_retire #(
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int PC_W   = 32
) (
  input  logic                 empty,
  input  logic                 h_valid,
  input  logic                 h_done,
  input  rob_pkg::rob_status_t h_status,
  input  logic [AREG_W-1:0]    h_dest,
  input  logic [PC_W-1:0]      h_pc,
  input  logic [DATA_W-1:0]    h_value,
  output logic                 retire,
  output logic                 ret_valid,
  output logic [AREG_W-1:0]    ret_dest,
  output logic [DATA_W-1:0]    ret_value,
  output logic                 flush_req,
  output logic [PC_W-1:0]      flush_pc
);
  logic flagged;

  always_comb begin
    retire    = !empty && h_valid && h_done;
    flagged   = rob_pkg::needs_flush(h_status);
    ret_valid = retire && !flagged;
    flush_req = retire && flagged;
    ret_dest  = h_dest;
    ret_value = h_value;
    flush_pc  = h_pc;
  end

endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int AREG_W = 5,
  parameter int PC_W   = 32,
  parameter int NCMP   = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        disp_valid,
  input  logic [AREG_W-1:0]           disp_dest,
  input  logic [PC_W-1:0]             disp_pc,
  output logic                        disp_ready,
  output logic [TAG_W-1:0]            disp_tag,
  input  logic [NCMP-1:0]             cmp_valid,
  input  logic [NCMP-1:0][TAG_W-1:0]  cmp_tag,
  input  logic [NCMP-1:0][DATA_W-1:0] cmp_value,
  input  logic [NCMP-1:0]             cmp_exc,
  input  logic [NCMP-1:0]             cmp_mis,
  output logic                        ret_valid,
  output logic [AREG_W-1:0]           ret_dest,
  output logic [DATA_W-1:0]           ret_value,
  output logic                        flush_req,
  output logic [PC_W-1:0]             flush_pc
);
  localparam int PTR_W = TAG_W + 1;

  logic [PTR_W-1:0] head_ptr, tail_ptr;
  logic             full, empty, retire, alloc, free_head;
  logic [TAG_W-1:0] head_idx, tail_idx;

  logic                 s_valid  [DEPTH];
  logic                 s_done   [DEPTH];
  rob_pkg::rob_status_t s_status [DEPTH];
  logic [AREG_W-1:0]    s_dest   [DEPTH];
  logic [PC_W-1:0]      s_pc     [DEPTH];
  logic [DATA_W-1:0]    s_value  [DEPTH];

  assign head_idx   = head_ptr[TAG_W-1:0];
  assign tail_idx   = tail_ptr[TAG_W-1:0];
  assign disp_ready = !full && !flush_req;
  assign alloc      = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;
  assign free_head  = retire && !flush_req;

  rob_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc(alloc), .retire(retire), .flush(flush_req),
    .head_ptr(head_ptr), .tail_ptr(tail_ptr), .full(full), .empty(empty)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    rob_slot #(
      .IDX(e), .TAG_W(TAG_W), .DATA_W(DATA_W), .AREG_W(AREG_W), .PC_W(PC_W), .NCMP(NCMP)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .clear_all(flush_req),
      .release_i(free_head && (head_idx == TAG_W'(e))),
      .alloc_i(alloc && (tail_idx == TAG_W'(e))),
      .alloc_dest(disp_dest), .alloc_pc(disp_pc),
      .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
      .cmp_exc(cmp_exc), .cmp_mis(cmp_mis),
      .valid_o(s_valid[e]), .done_o(s_done[e]), .status_o(s_status[e]),
      .dest_o(s_dest[e]), .pc_o(s_pc[e]), .value_o(s_value[e])
    );
  end

  rob_retire #(.DATA_W(DATA_W), .AREG_W(AREG_W), .PC_W(PC_W)) u_ret (
    .empty(empty), .h_valid(s_valid[head_idx]), .h_done(s_done[head_idx]),
    .h_status(s_status[head_idx]), .h_dest(s_dest[head_idx]), .h_pc(s_pc[head_idx]),
    .h_value(s_value[head_idx]), .retire(retire), .ret_valid(ret_valid),
    .ret_dest(ret_dest), .ret_value(ret_value), .flush_req(flush_req), .flush_pc(flush_pc)
  );

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !disp_ready);  // R6
  AST_TAG_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (disp_tag == $past(disp_tag) + TAG_W'(1)));  // R2
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (!ret_valid && !flush_req));  // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_valid && flush_req));  // R7
  AST_FLUSH_NO_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !disp_ready);  // R10

endmodule

// File: tb/sim_reorder_buffer.sv
`timescale 1ns/100ps
module sim_reorder_buffer;
  logic             clk = 1'b0;
  logic             rst_n;
  logic             disp_valid;
  logic [4:0]       disp_dest;
  logic [31:0]      disp_pc;
  logic             disp_ready;
  logic [3:0]       disp_tag;
  logic [1:0]       cmp_valid;
  logic [1:0][3:0]  cmp_tag;
  logic [1:0][31:0] cmp_value;
  logic [1:0]       cmp_exc, cmp_mis;
  logic             ret_valid;
  logic [4:0]       ret_dest;
  logic [31:0]      ret_value;
  logic             flush_req;
  logic [31:0]      flush_pc;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  reorder_buffer u0 (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dest(disp_dest),
    .disp_pc(disp_pc), .disp_ready(disp_ready), .disp_tag(disp_tag),
    .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
    .cmp_exc(cmp_exc), .cmp_mis(cmp_mis), .ret_valid(ret_valid),
    .ret_dest(ret_dest), .ret_value(ret_value), .flush_req(flush_req), .flush_pc(flush_pc)
  );

  // {dest, value}
  localparam logic [36:0] VEC [8] = '{
    {5'd1,  32'h1111_0001}, {5'd2,  32'h2222_0002}, {5'd9,  32'hDEAD_BEEF},
    {5'd31, 32'h0000_0000}, {5'd0,  32'hFFFF_FFFF}, {5'd17, 32'h1234_5678},
    {5'd5,  32'h8000_0000}, {5'd12, 32'h0BAD_F00D}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cmp_clear();
    cmp_valid = '0; cmp_exc = '0; cmp_mis = '0;
    cmp_tag = '0; cmp_value = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; disp_valid = 1'b0; disp_dest = '0; disp_pc = '0;
    cmp_clear();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    chk("R1 disp_ready", 64'(disp_ready), 64'd1);
    chk("R1 disp_tag",   64'(disp_tag),   64'd0);
    chk("R1 ret_valid",  64'(ret_valid),  64'd0);
    chk("R1 flush_req",  64'(flush_req),  64'd0);

    // Table: dispatch eight, complete in reverse two per cycle, retire in order.
    for (int i = 0; i < 8; i++) begin
      disp_valid = 1'b1; disp_dest = VEC[i][36:32]; disp_pc = 32'h400 + 32'(4*i);
      chk("R2 tag", 64'(disp_tag), 64'(i));
      step();
    end
    disp_valid = 1'b0;
    for (int c = 0; c < 4; c++) begin
      cmp_valid = 2'b11;
      cmp_tag[0] = 4'(7 - 2*c); cmp_value[0] = VEC[7 - 2*c][31:0];
      cmp_tag[1] = 4'(6 - 2*c); cmp_value[1] = VEC[6 - 2*c][31:0];
      chk("R4 waits for oldest", 64'(ret_valid), 64'd0);
      step();
    end
    cmp_clear();
    for (int i = 0; i < 8; i++) begin
      chk("R4 retire valid", 64'(ret_valid), 64'd1);
      chk("R5 dest",  64'(ret_dest),  64'(VEC[i][36:32]));
      chk("R3 value", 64'(ret_value), 64'(VEC[i][31:0]));
      step();
    end
    chk("R4 drained", 64'(ret_valid), 64'd0);

    // R10: completion to a free slot is dropped.
    cmp_valid[0] = 1'b1; cmp_tag[0] = 4'd9; cmp_value[0] = 32'h5555_5555; cmp_exc[0] = 1'b1;
    disp_valid = 1'b1; disp_dest = 5'd3; disp_pc = 32'h800;
    chk("R2 tag 8", 64'(disp_tag), 64'd8);
    step();
    cmp_clear();
    disp_dest = 5'd4; disp_pc = 32'h804;
    chk("R2 tag 9", 64'(disp_tag), 64'd9);
    step();
    disp_valid = 1'b0;
    cmp_valid[0] = 1'b1; cmp_tag[0] = 4'd8; cmp_value[0] = 32'hA5A5_0008;
    step();
    cmp_clear();
    chk("R5 dest 8",  64'(ret_dest),  64'd3);
    chk("R5 value 8", 64'(ret_value), 64'hA5A5_0008);
    step();
    chk("R10 free write ignored ret", 64'(ret_valid), 64'd0);
    chk("R10 free write ignored flush", 64'(flush_req), 64'd0);
    cmp_valid[1] = 1'b1; cmp_tag[1] = 4'd9; cmp_value[1] = 32'hA5A5_0009;
    step();
    cmp_clear();
    chk("R5 dest 9", 64'(ret_dest), 64'd4);
    chk("R4 valid 9", 64'(ret_valid), 64'd1);
    step();

    // Fill to 16 across the wrap.
    for (int i = 0; i < 16; i++) begin
      disp_valid = 1'b1; disp_dest = 5'(i + 1); disp_pc = 32'h2000 + 32'(4*i);
      chk("R11 tag wrap", 64'(disp_tag), 64'((10 + i) % 16));
      step();
    end
    disp_valid = 1'b0;
    chk("R6 full not ready", 64'(disp_ready), 64'd0);
    disp_valid = 1'b1; disp_dest = 5'd31; disp_pc = 32'hDEAD_0000;
    step();
    disp_valid = 1'b0;
    cmp_valid[0] = 1'b1; cmp_tag[0] = 4'd10; cmp_value[0] = 32'h0000_0A0A;
    step();
    cmp_clear();
    chk("R5 dest 10", 64'(ret_dest), 64'd1);
    chk("R6 still full", 64'(disp_ready), 64'd0);
    step();
    chk("R6 ready after retire", 64'(disp_ready), 64'd1);
    chk("R6 ignored dispatch", 64'(disp_tag), 64'd10);

    // R7: exception on oldest, younger already finished.
    cmp_valid = 2'b11;
    cmp_tag[0] = 4'd11; cmp_value[0] = 32'h0; cmp_exc[0] = 1'b1;
    cmp_tag[1] = 4'd12; cmp_value[1] = 32'h0C0C;
    step();
    cmp_clear();
    chk("R7 flush", 64'(flush_req), 64'd1);
    chk("R7 flush_pc", 64'(flush_pc), 64'h2004);
    chk("R7 no reg write", 64'(ret_valid), 64'd0);
    chk("R10 no dispatch in flush", 64'(disp_ready), 64'd0);
    step();
    chk("R9 flush ends", 64'(flush_req), 64'd0);
    chk("R9 younger dropped", 64'(ret_valid), 64'd0);
    chk("R9 next tag", 64'(disp_tag), 64'd12);
    chk("R9 ready", 64'(disp_ready), 64'd1);

    // R8: branch mismatch.
    disp_valid = 1'b1; disp_dest = 5'd7; disp_pc = 32'h3000;
    step();
    disp_valid = 1'b0;
    cmp_valid[1] = 1'b1; cmp_tag[1] = 4'd12; cmp_value[1] = 32'h77; cmp_mis[1] = 1'b1;
    step();
    cmp_clear();
    chk("R8 flush", 64'(flush_req), 64'd1);
    chk("R8 flush_pc", 64'(flush_pc), 64'h3000);
    chk("R8 no reg write", 64'(ret_valid), 64'd0);
    step();
    chk("R9 tag after mismatch", 64'(disp_tag), 64'd13);
    chk("R9 quiet", 64'(flush_req), 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule